// File: doc/BRIEF.md
# Cell-Stream Descriptor Receive Engine

This block is the receive half of a descriptor-driven buffer engine for frames carried as fixed 48-byte cells on one channel. It owns one descriptor at a time, taken from a software-built free chain held in a descriptor table memory. It stores the payload words of each arriving frame into the buffer that the descriptor names. When the cell flagged as last in the frame arrives, the engine first claims the next free descriptor. Only then does it write the finished descriptor back with its completion status.

Each descriptor is two 32-bit words, at table word addresses `2*idx` and `2*idx+1`. The first word is the status word. The second word is the link word: bits [7:0] hold the index of the next descriptor and bits [23:16] hold the buffer number. Buffers are 2048 bytes, which is 512 words. Once a descriptor has been written back, the engine publishes its index on a notify register and then raises a one-cycle interrupt. After that interrupt it stays silent until software re-arms it.

Top module: `desc_rx_engine`

## Requirements
- R1: The engine claims a descriptor only if bits [1:0] of its status word read 3 (software-owned, ready). A value of 2 (held) marks the end of the chain: that descriptor is left unwritten and is not used.
- R2: At the end of a frame, the engine reads the next descriptor before it writes back the finished one. The written-back sync field [1:0] is 0 if the next descriptor was ready and 1 if it was not.
- R3: The written-back status word has bit 7 = 1 (end of frame), bit 6 = CRC-good marker, bit 5 = loss-priority bit of the last cell, and bit 4 = congestion bit. The congestion bit is PTI bit 1 of the last cell, and only for user-data cells (PTI bit 2 = 0). All other bits below 16 are zero.
- R4: Bits [3:2] carry the buffer type, taken from the last cell's PTI. PTI 0xx gives 0 (data), 11x gives 1 (resource management), 100 gives 2 (segment OAM) and 101 gives 3 (end-to-end OAM).
- R5: Word w of cell c is written to buffer word address `buf*512 + c*12 + w`, where buf is link-word bits [23:16]. The next descriptor index is link-word bits [7:0].
- R6: Status bits [27:16] hold the number of bytes actually stored. At most 42 cells (2016 bytes) are stored per frame; words of any later cell are not written.
- R7: Completion runs in a fixed order: the status write-back, then one cycle with `notify_stb` high and `notify_idx` set to the finished index, then the interrupt in the next cycle.
- R8: The interrupt is a one-cycle pulse. It disables itself when it fires. Later completions still update the notify register but raise no interrupt until `irq_rearm` is pulsed.
- R9: If no ready descriptor is available when a frame starts, every word up to the last-cell marker is consumed without any buffer write. `drop_cnt` then increments. The same descriptor index is tried again at the next frame start.
- R10: After reset, `in_ready`, `irq`, `notify_stb`, `notify_idx` and `drop_cnt` are all 0. The first frame start fetches descriptor 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Engine accepts the word this cycle |
| in_word | input | 32 | Payload word |
| in_wlast | input | 1 | Last word of the current cell |
| in_eof | input | 1 | Current cell is the last of the frame |
| in_crc_ok | input | 1 | Frame CRC good (sampled on the last word of the frame) |
| in_clp | input | 1 | Loss-priority bit of the cell |
| in_pti | input | 3 | Payload-type bits of the cell |
| dt_addr | output | 9 | Descriptor table word address |
| dt_re | output | 1 | Descriptor table read; data returns next cycle |
| dt_we | output | 1 | Descriptor table write |
| dt_wdata | output | 32 | Descriptor table write data |
| dt_rdata | input | 32 | Descriptor table read data |
| buf_we | output | 1 | Buffer word write |
| buf_addr | output | 17 | Buffer word address |
| buf_wdata | output | 32 | Buffer write data |
| notify_idx | output | 8 | Index of the most recently completed descriptor |
| notify_stb | output | 1 | Notify register updated |
| irq | output | 1 | Interrupt pulse |
| irq_rearm | input | 1 | Re-enable the interrupt |
| drop_cnt | output | 16 | Frames dropped for lack of a descriptor |

## Verification
The bench drives frames whose last cells carry every class of payload type. It checks each written-back word bit for bit, so a wrong PTI decode, or a congestion flag taken from an OAM cell, shows up directly. One frame is longer than 42 cells: an engine without the cap would write past the frame limit and report too large a length. The chain is run dry, so an engine that writes back before it fetches, or that always reports a valid link, marks the link field wrong. A frame is sent into the empty chain and a descriptor is then re-readied. This catches an engine that writes the held descriptor, forgets to count the drop, or skips the retry. A frame completed while the interrupt is disabled exposes an interrupt that re-arms itself.

// File: rtl/dre_pkg.sv
package dre_pkg;

  // Sync field values of a descriptor status word
  localparam logic [1:0] SYNC_DONE_LINKED   = 2'd0;
  localparam logic [1:0] SYNC_DONE_UNLINKED = 2'd1;
  localparam logic [1:0] SYNC_HELD          = 2'd2;
  localparam logic [1:0] SYNC_OWNED         = 2'd3;

  // Status word bit positions
  localparam int F_SYNC = 0;
  localparam int F_TYPE = 2;
  localparam int F_CONG = 4;
  localparam int F_LOSS = 5;
  localparam int F_CRC  = 6;
  localparam int F_EOF  = 7;
  localparam int F_LEN  = 16;
  // Link word position of the buffer number
  localparam int F_BUF  = 16;

  typedef enum logic [1:0] {
    BT_DATA    = 2'd0,
    BT_RM      = 2'd1,
    BT_SEG_OAM = 2'd2,
    BT_E2E_OAM = 2'd3
  } btype_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_DROP, ST_F0, ST_F1, ST_F2, ST_WB, ST_NOTE
  } st_e;

  function automatic btype_e pti_class(input logic [2:0] pti);
    if (!pti[2])     return BT_DATA;
    else if (pti[1]) return BT_RM;
    else if (pti[0]) return BT_E2E_OAM;
    else             return BT_SEG_OAM;
  endfunction

endpackage

// File: rtl/dre_status_pack.sv
module dre_status_pack
  import dre_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic [LEN_W-1:0] len,
  input  logic             crc_ok,
  input  logic             clp,
  input  logic [2:0]       pti,
  input  logic             link_ok,
  output logic [31:0]      word
);
  always_comb begin
    word                  = '0;
    word[F_SYNC +: 2]     = link_ok ? SYNC_DONE_LINKED : SYNC_DONE_UNLINKED;
    word[F_TYPE +: 2]     = pti_class(pti);
    word[F_CONG]          = ~pti[2] & pti[1];
    word[F_LOSS]          = clp;
    word[F_CRC]           = crc_ok;
    word[F_EOF]           = 1'b1;
    word[F_LEN +: LEN_W]  = len;
  end
endmodule

// File: rtl/dre_buf_wr.sv
module dre_buf_wr #(
  parameter int BUFN_W    = 8,
  parameter int OFF_W     = 9,
  parameter int LEN_W     = 12,
  parameter int WPC       = 12,
  parameter int MAX_CELLS = 42
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    first,
  input  logic                    wlast,
  input  logic [BUFN_W-1:0]       base,
  input  logic [31:0]             din,
  output logic                    buf_we,
  output logic [BUFN_W+OFF_W-1:0] buf_addr,
  output logic [31:0]             buf_wdata,
  output logic [LEN_W-1:0]        len
);
  localparam int WIX_W = $clog2(WPC);
  localparam int CNT_W = $clog2(MAX_CELLS + 1);

  logic [WIX_W-1:0] woff, woff_eff;
  logic [CNT_W-1:0] cells, cells_eff;
  logic [LEN_W-1:0] len_eff;
  logic             store;

  always_comb begin
    woff_eff  = first ? '0 : woff;
    cells_eff = first ? '0 : cells;
    len_eff   = first ? '0 : len;
    store     = wr && (cells_eff < CNT_W'(MAX_CELLS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      woff      <= '0;
      cells     <= '0;
      len       <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
    end else begin
      buf_we <= store;
      if (store) begin
        buf_addr  <= {base, OFF_W'(cells_eff) * OFF_W'(WPC) + OFF_W'(woff_eff)};
        buf_wdata <= din;
      end
      if (wr) begin
        woff  <= wlast ? '0 : woff_eff + 1'b1;
        cells <= cells_eff + CNT_W'(store && wlast);
        len   <= len_eff + (store ? LEN_W'(4) : '0);
      end
    end
  end
endmodule

// File: rtl/desc_rx_engine.sv
module desc_rx_engine
  import dre_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int BUFN_W     = 8,
  parameter int BUF_BYTES  = 2048,
  parameter int CELL_BYTES = 48,
  parameter int MAX_CELLS  = 42,
  parameter int HEAD_IDX   = 1,
  parameter int DROP_W     = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     in_valid,
  output logic                                     in_ready,
  input  logic [31:0]                              in_word,
  input  logic                                     in_wlast,
  input  logic                                     in_eof,
  input  logic                                     in_crc_ok,
  input  logic                                     in_clp,
  input  logic [2:0]                               in_pti,
  output logic [IDX_W:0]                           dt_addr,
  output logic                                     dt_re,
  output logic                                     dt_we,
  output logic [31:0]                              dt_wdata,
  input  logic [31:0]                              dt_rdata,
  output logic                                     buf_we,
  output logic [BUFN_W+$clog2(BUF_BYTES/4)-1:0]    buf_addr,
  output logic [31:0]                              buf_wdata,
  output logic [IDX_W-1:0]                         notify_idx,
  output logic                                     notify_stb,
  output logic                                     irq,
  input  logic                                     irq_rearm,
  output logic [DROP_W-1:0]                        drop_cnt
);
  localparam int WPC   = CELL_BYTES / 4;
  localparam int OFF_W = $clog2(BUF_BYTES / 4);
  localparam int LEN_W = $clog2(BUF_BYTES) + 1;

  st_e               st;
  logic              have_cur, for_eof, link_ok, irq_en;
  logic [IDX_W-1:0]  cand, cur_idx, cur_next, wb_idx;
  logic [BUFN_W-1:0] cur_buf;
  logic              eof_crc, eof_clp;
  logic [2:0]        eof_pti;
  logic [LEN_W-1:0]  frame_len;
  logic [31:0]       wb_word;
  logic              accept, take, first, frame_end, rd_ready;

  assign in_ready  = (st == ST_RECV) || (st == ST_DROP) || (st == ST_IDLE && have_cur);
  assign accept    = in_valid && in_ready;
  assign take      = accept && (st != ST_DROP);
  assign first     = accept && (st == ST_IDLE);
  assign frame_end = accept && in_wlast && in_eof;
  assign rd_ready  = (dt_rdata[F_SYNC +: 2] == SYNC_OWNED);
  assign notify_stb = (st == ST_NOTE);

  // Descriptor table port: status read, link read, status write-back
  always_comb begin
    dt_re    = 1'b0;
    dt_we    = 1'b0;
    dt_addr  = {cand, 1'b0};
    dt_wdata = wb_word;
    case (st)
      ST_F0: dt_re = 1'b1;
      ST_F1: begin
        dt_addr = {cand, 1'b1};
        dt_re   = rd_ready;
      end
      ST_WB: begin
        dt_we   = 1'b1;
        dt_addr = {wb_idx, 1'b0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      have_cur   <= 1'b0;
      for_eof    <= 1'b0;
      link_ok    <= 1'b0;
      cand       <= IDX_W'(HEAD_IDX);
      cur_idx    <= '0;
      cur_next   <= '0;
      cur_buf    <= '0;
      wb_idx     <= '0;
      eof_crc    <= 1'b0;
      eof_clp    <= 1'b0;
      eof_pti    <= '0;
      irq        <= 1'b0;
      irq_en     <= 1'b1;
      notify_idx <= '0;
      drop_cnt   <= '0;
    end else begin
      irq <= 1'b0;
      if (irq_rearm) irq_en <= 1'b1;
      case (st)
        ST_IDLE, ST_RECV: begin
          if (st == ST_IDLE && !have_cur && in_valid) begin
            for_eof <= 1'b0;
            st      <= ST_F0;
          end else if (take) begin
            if (frame_end) begin
              for_eof <= 1'b1;
              wb_idx  <= cur_idx;
              cand    <= cur_next;
              eof_crc <= in_crc_ok;
              eof_clp <= in_clp;
              eof_pti <= in_pti;
              st      <= ST_F0;
            end else begin
              st <= ST_RECV;
            end
          end
        end
        ST_DROP: begin
          if (frame_end) begin
            drop_cnt <= drop_cnt + 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_F0: st <= ST_F1;
        ST_F1: begin
          if (rd_ready) begin
            st <= ST_F2;
          end else begin
            have_cur <= 1'b0;
            link_ok  <= 1'b0;
            st       <= for_eof ? ST_WB : ST_DROP;
          end
        end
        ST_F2: begin
          cur_idx  <= cand;
          cur_buf  <= dt_rdata[F_BUF +: BUFN_W];
          cur_next <= dt_rdata[IDX_W-1:0];
          have_cur <= 1'b1;
          link_ok  <= 1'b1;
          st       <= for_eof ? ST_WB : ST_IDLE;
        end
        ST_WB: begin
          notify_idx <= wb_idx;
          st         <= ST_NOTE;
        end
        ST_NOTE: begin
          if (irq_en) begin
            irq    <= 1'b1;
            irq_en <= 1'b0;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  dre_status_pack #(.LEN_W(LEN_W)) u_pack (
    .len     (frame_len),
    .crc_ok  (eof_crc),
    .clp     (eof_clp),
    .pti     (eof_pti),
    .link_ok (link_ok),
    .word    (wb_word)
  );

  dre_buf_wr #(
    .BUFN_W    (BUFN_W),
    .OFF_W     (OFF_W),
    .LEN_W     (LEN_W),
    .WPC       (WPC),
    .MAX_CELLS (MAX_CELLS)
  ) u_wr (
    .clk       (clk),
    .rst       (rst),
    .wr        (take),
    .first     (first),
    .wlast     (in_wlast),
    .base      (cur_buf),
    .din       (in_word),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_wdata (buf_wdata),
    .len       (frame_len)
  );
endmodule

// File: rtl/desc_rx_engine_chk.sv
module desc_rx_engine_chk #(
  parameter int OFF_W  = 9,
  parameter int LIM    = 504,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_wlast,
  input logic              in_eof,
  input logic              dt_re,
  input logic              dt_we,
  input logic [31:0]       dt_wdata,
  input logic              buf_we,
  input logic [OFF_W-1:0]  buf_off,
  input logic              notify_stb,
  input logic              irq,
  input logic [DROP_W-1:0] drop_cnt
);
  // R2: a write-back always follows a fetch read two cycles before
  a_r2_fetch_before_wb: assert property (@(posedge clk) disable iff (rst)
    dt_we |-> $past(dt_re, 2));

  // R3: written-back status always carries end of frame and a done sync value
  a_r3_wb_done: assert property (@(posedge clk) disable iff (rst)
    dt_we |-> (dt_wdata[7] && !dt_wdata[1]));

  // R6: no buffer write beyond the frame cell limit
  a_r6_cap: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (32'(buf_off) < LIM));

  // R7: notify strictly after write-back, interrupt strictly after notify
  a_r7_note_after_wb: assert property (@(posedge clk) disable iff (rst)
    notify_stb |-> $past(dt_we));
  a_r7_irq_after_note: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(notify_stb));

  // R8: interrupt is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R9: drop counter moves only on an accepted last word of a frame
  a_r9_drop_on_eof: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt != $past(drop_cnt)) |-> $past(in_valid && in_ready && in_wlast && in_eof));

  // R1: table is never read and written in the same cycle
  a_r1_port_excl: assert property (@(posedge clk) disable iff (rst)
    !(dt_re && dt_we));
endmodule

bind desc_rx_engine desc_rx_engine_chk #(
  .OFF_W  ($clog2(BUF_BYTES/4)),
  .LIM    (MAX_CELLS*(CELL_BYTES/4)),
  .DROP_W (DROP_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_wlast   (in_wlast),
  .in_eof     (in_eof),
  .dt_re      (dt_re),
  .dt_we      (dt_we),
  .dt_wdata   (dt_wdata),
  .buf_we     (buf_we),
  .buf_off    (buf_addr[$clog2(BUF_BYTES/4)-1:0]),
  .notify_stb (notify_stb),
  .irq        (irq),
  .drop_cnt   (drop_cnt)
);

// File: tb/desc_rx_engine_bench.sv
`timescale 1ns/1ps
module desc_rx_engine_bench;
  typedef struct packed {
    logic [7:0]  idx;
    logic [7:0]  ncells;
    logic        crc;
    logic        clp;
    logic [2:0]  pti;
    logic        rearm;
    logic [31:0] exp;
  } vec_t;

  // Status expectations: len[27:16] | E 0x80 | C 0x40 | L 0x20 | X 0x10 | type<<2 | sync
  localparam vec_t VECS [5] = '{
    '{8'd1, 8'd1,  1'b1, 1'b0, 3'b000, 1'b1, 32'h003000C0},
    '{8'd2, 8'd3,  1'b0, 1'b1, 3'b010, 1'b0, 32'h009000B0},
    '{8'd3, 8'd2,  1'b1, 1'b0, 3'b101, 1'b1, 32'h006000CC},
    '{8'd4, 8'd1,  1'b1, 1'b1, 3'b110, 1'b1, 32'h003000E4},
    '{8'd5, 8'd45, 1'b1, 1'b0, 3'b011, 1'b1, 32'h07E000D0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 0, in_wlast = 0, in_eof = 0, in_crc_ok = 0, in_clp = 0;
  logic [31:0] in_word = '0;
  logic [2:0]  in_pti = '0;
  logic        in_ready;
  logic [8:0]  dt_addr;
  logic        dt_re, dt_we;
  logic [31:0] dt_wdata, dt_rdata;
  logic        buf_we;
  logic [16:0] buf_addr;
  logic [31:0] buf_wdata;
  logic [7:0]  notify_idx;
  logic        notify_stb, irq;
  logic        irq_rearm = 1'b0;
  logic [15:0] drop_cnt;

  logic        sw_we = 1'b0;
  logic [8:0]  sw_addr = '0;
  logic [31:0] sw_data = '0;
  logic [31:0] dmem [0:511];

  int checks = 0, errs = 0;
  int wr_cnt = 0, irq_cnt = 0, mark = 0;
  logic [16:0] first_addr = '0;
  logic [31:0] first_data = '0;

  always #2.5 clk = ~clk;

  desc_rx_engine u_desc_rx_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .in_wlast(in_wlast), .in_eof(in_eof), .in_crc_ok(in_crc_ok), .in_clp(in_clp),
    .in_pti(in_pti), .dt_addr(dt_addr), .dt_re(dt_re), .dt_we(dt_we), .dt_wdata(dt_wdata),
    .dt_rdata(dt_rdata), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .notify_idx(notify_idx), .notify_stb(notify_stb), .irq(irq), .irq_rearm(irq_rearm),
    .drop_cnt(drop_cnt)
  );

  // Descriptor table model: one-cycle read latency, software port for setup
  always @(posedge clk) begin
    if (sw_we) dmem[sw_addr] <= sw_data;
    else if (dt_we) dmem[dt_addr] <= dt_wdata;
    if (dt_re) dt_rdata <= dmem[dt_addr];
  end

  always @(negedge clk) begin
    if (buf_we) begin
      if (wr_cnt == mark) begin
        first_addr = buf_addr;
        first_data = buf_wdata;
      end
      wr_cnt = wr_cnt + 1;
    end
    if (irq) irq_cnt = irq_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = a; sw_data = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); irq_rearm = 1'b1;
    @(negedge clk); irq_rearm = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] idx, input int n, input logic crc,
                            input logic clp, input logic [2:0] pti);
    for (int c = 0; c < n; c++) begin
      for (int w = 0; w < 12; w++) begin
        @(negedge clk);
        in_valid = 1'b1; in_word = {idx, 8'(c), 16'(w)};
        in_wlast = (w == 11); in_eof = (c == n - 1);
        in_crc_ok = crc; in_clp = clp; in_pti = pti;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_wlast = 1'b0; in_eof = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int w0, i0, nstore;
    // Chain: descriptors 1..6 ready, each linked to the next; 7 and 8 held
    for (int i = 1; i <= 6; i++) begin
      sw_write(9'(2 * i), 32'h3);
      sw_write(9'(2 * i + 1), {8'h0, 8'(i + 16), 8'h0, 8'(i + 1)});
    end
    sw_write(9'd14, 32'h2);
    sw_write(9'd15, {8'h0, 8'd23, 8'h0, 8'd8});
    sw_write(9'd16, 32'h2);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 in_ready", 32'(in_ready), 32'd0);
    chk("R10 irq", 32'(irq), 32'd0);
    chk("R10 drop_cnt", 32'(drop_cnt), 32'd0);
    chk("R10 notify", {23'd0, notify_stb, notify_idx}, 32'd0);

    for (int v = 0; v < 5; v++) begin
      if (VECS[v].rearm) rearm();
      w0 = wr_cnt; i0 = irq_cnt; mark = wr_cnt;
      send_frame(VECS[v].idx, int'(VECS[v].ncells), VECS[v].crc, VECS[v].clp, VECS[v].pti);
      nstore = (VECS[v].ncells > 42) ? 42 : int'(VECS[v].ncells);
      chk("R3 status word", dmem[2 * VECS[v].idx], VECS[v].exp);
      chk("R4 type field", 32'(dmem[2 * VECS[v].idx][3:2]), 32'(VECS[v].exp[3:2]));
      chk("R7 notify index", 32'(notify_idx), 32'(VECS[v].idx));
      chk("R6 stored words", 32'(wr_cnt - w0), 32'(nstore * 12));
      chk("R5 first buffer address", 32'(first_addr), 32'({VECS[v].idx + 8'd16, 9'h0}));
      chk("R5 first buffer data", first_data, {VECS[v].idx, 24'h0});
      chk("R8 irq pulses", 32'(irq_cnt - i0), 32'(VECS[v].rearm));
    end

    // R2: next descriptor (7) held -> unlinked completion
    rearm();
    w0 = wr_cnt; i0 = irq_cnt; mark = wr_cnt;
    send_frame(8'd6, 2, 1'b1, 1'b0, 3'b100);
    chk("R2 unlinked write-back", dmem[12], 32'h006000C9);
    chk("R7 notify index", 32'(notify_idx), 32'd6);
    chk("R8 irq after rearm", 32'(irq_cnt - i0), 32'd1);
    chk("R5 buffer of desc 6", 32'(first_addr), 32'({8'd22, 9'h0}));

    // R9: empty chain -> frame dropped, held descriptor untouched
    rearm();
    w0 = wr_cnt; i0 = irq_cnt;
    send_frame(8'd7, 2, 1'b1, 1'b0, 3'b000);
    chk("R9 drop count", 32'(drop_cnt), 32'd1);
    chk("R9 no buffer writes", 32'(wr_cnt - w0), 32'd0);
    chk("R1 held descriptor untouched", dmem[14], 32'h2);
    chk("R9 notify unchanged", 32'(notify_idx), 32'd6);
    chk("R9 no irq on drop", 32'(irq_cnt - i0), 32'd0);

    // R9 retry: software readies descriptor 7, next frame lands there
    sw_write(9'd14, 32'h3);
    w0 = wr_cnt; mark = wr_cnt;
    send_frame(8'd7, 1, 1'b0, 1'b0, 3'b000);
    chk("R9 retried descriptor", dmem[14], 32'h00300081);
    chk("R9 notify retried", 32'(notify_idx), 32'd7);
    chk("R5 buffer of desc 7", 32'(first_addr), 32'({8'd23, 9'h0}));
    chk("R1 chain end untouched", dmem[16], 32'h2);
    chk("R9 drop count stable", 32'(drop_cnt), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule